// File: doc/BRIEF.md
# Stride-Counting Stream Sample Generator

This block is a stream master that turns a free-running internal counter into a sequence of 32-bit samples. The counter grows in steps of three. Only the counter values whose two lowest bits are both zero, the multiples of four, are put on the output. Starting from zero after reset, the stream therefore carries 0, 12, 24, 36 and so on, and no value in that sequence is ever skipped.

Each sample is a packet of one beat, so the end-of-packet flag always equals the valid flag. Once a sample is offered it stays on the bus until the receiver takes it, however long the receiver stalls. Between an accepted sample and the next one the counter passes through three values that are not multiples of four. This gives exactly three idle cycles. A build-time start value lets the counter begin elsewhere, which is how wraparound at 2^32 is exercised.

Top module: `sample_gen_axis`

## Requirements
- R1: Reset (`rst_n` low, sampled on the rising clock edge) forces `m_tvalid` and `m_tlast` low and loads the counter with the start value INIT (default 0, a multiple of 4). On the first rising edge after `rst_n` is seen high, the block offers the INIT sample.
- R2: `m_tvalid` is high only when bits [1:0] of `m_tdata` are both 0.
- R3: While `m_tvalid` is high and `m_tready` is low at a rising edge, `m_tvalid` stays high and `m_tdata` keeps its value after that edge.
- R4: On a rising edge with both `m_tvalid` and `m_tready` high, the counter adds 3 and `m_tvalid` is low in the following cycle.
- R5: While no sample is offered, `m_tdata` shows the full counter value, which adds 3 on every rising edge whatever `m_tready` does. As a result, exactly three cycles with `m_tvalid` low lie between an accepted sample and the next offer.
- R6: `m_tlast` always equals `m_tvalid`, so every sample is a one-beat packet.
- R7: With INIT = 0, the accepted samples are 0, 12, 24, 36, and so on, each 12 greater than the last, with none skipped or repeated.
- R8: The counter wraps modulo 2^32. With INIT = 0xFFFFFFF0, the accepted samples are 0xFFFFFFF0, 0xFFFFFFFC, 0x00000008, 0x00000014, and so on, each 12 greater modulo 2^32.
- R9: No output depends combinationally on `m_tready`. Changing `m_tready` between clock edges leaves `m_tvalid`, `m_tlast` and `m_tdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| m_tready | input | 1 | Receiver is able to take the current beat |
| m_tdata | output | 32 | Counter value; this is the sample when valid is high |
| m_tvalid | output | 1 | A sample is offered |
| m_tlast | output | 1 | End of packet, equal to m_tvalid |

## Verification
The assertions assume that `m_tready` and `rst_n` change only between clock edges and never hold an unknown value at an edge. The bench meets this by driving both inputs just after the falling edge. The hold and drop properties also assume that the receiver reads the beat only at a rising edge. The bench counts a beat as taken only when it held `m_tready` high across that edge. Its random backpressure mixes long stalls, full-rate acceptance and sparse readiness, and it includes a reset in the middle of the stream, so every branch the properties guard is reached.

// File: rtl/sgen_pkg.sv
package sgen_pkg;

    localparam int unsigned SG_DATA_W   = 32;
    localparam int unsigned SG_STRIDE   = 3;
    localparam int unsigned SG_SEL_BITS = 2;

    typedef enum logic {
        SG_GAP   = 1'b0,
        SG_OFFER = 1'b1
    } sg_phase_e;

endpackage

// File: rtl/sgen_step.sv
module sgen_step #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned STRIDE   = 3,
    parameter int unsigned SEL_BITS = 2,
    parameter logic [DATA_W-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [DATA_W-1:0] count,
    output logic              cur_hit,
    output logic              nxt_hit
);

    localparam logic [DATA_W-1:0] STEP = DATA_W'(STRIDE);

    logic [DATA_W-1:0] nxt;

    always_comb begin
        nxt     = advance ? count + STEP : count;
        cur_hit = ~|count[SEL_BITS-1:0];
        nxt_hit = ~|nxt[SEL_BITS-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count <= INIT;
        else        count <= nxt;
    end

    // R4 / R5: each advance moves the counter by exactly one stride
    a_r5_stride_step: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> count == $past(count) + STEP);

    // R3: no advance means the counter holds
    a_r3_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(count));

endmodule

// File: rtl/sgen_ctrl.sv
module sgen_ctrl
    import sgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic cur_hit,
    input  logic nxt_hit,
    output logic valid,
    output logic advance
);

    sg_phase_e phase;

    assign valid = (phase == SG_OFFER);

    always_comb begin
        if (phase == SG_OFFER) advance = ready;
        else                   advance = ~cur_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase <= SG_GAP;
        else        phase <= nxt_hit ? SG_OFFER : SG_GAP;
    end

    // R4: accepted beat is followed by a cycle without valid
    a_r4_drop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        valid && ready |=> !valid);

    // R3: an offered beat is never withdrawn while stalled
    a_r3_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> valid);

    // R5: with no offer pending the counter keeps moving
    a_r5_gap_moves: assert property (@(posedge clk) disable iff (!rst_n)
        !valid && !cur_hit |-> advance);

endmodule

// File: rtl/sample_gen_axis.sv
module sample_gen_axis
    import sgen_pkg::*;
#(
    parameter int unsigned DATA_W   = SG_DATA_W,
    parameter int unsigned STRIDE   = SG_STRIDE,
    parameter int unsigned SEL_BITS = SG_SEL_BITS,
    parameter logic [DATA_W-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    output logic              m_tlast
);

    logic advance;
    logic cur_hit;
    logic nxt_hit;

    sgen_step #(
        .DATA_W  (DATA_W),
        .STRIDE  (STRIDE),
        .SEL_BITS(SEL_BITS),
        .INIT    (INIT)
    ) u_step (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(advance),
        .count  (m_tdata),
        .cur_hit(cur_hit),
        .nxt_hit(nxt_hit)
    );

    sgen_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ready  (m_tready),
        .cur_hit(cur_hit),
        .nxt_hit(nxt_hit),
        .valid  (m_tvalid),
        .advance(advance)
    );

    assign m_tlast = m_tvalid;

    // R3: stalled beat keeps its data
    a_r3_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata));

    // R2: offered samples sit on a multiple of four
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> ~|m_tdata[SEL_BITS-1:0]);

    // R7: after acceptance the data moves on
    a_r7_data_moves: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && m_tready |=> m_tdata != $past(m_tdata));

endmodule

// File: tb/sample_gen_axis_test.sv
module sample_gen_axis_test;

    localparam logic [31:0] INITS [2] = '{32'h0000_0000, 32'hFFFF_FFF0};

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n  = 1'b0;
    logic tready = 1'b0;
    logic [1:0][31:0] td;
    logic [1:0]       tv;
    logic [1:0]       tl;

    sample_gen_axis uut (
        .clk(clk), .rst_n(rst_n), .m_tready(tready),
        .m_tdata(td[0]), .m_tvalid(tv[0]), .m_tlast(tl[0])
    );

    sample_gen_axis #(.INIT(32'hFFFF_FFF0)) uut_wrap (
        .clk(clk), .rst_n(rst_n), .m_tready(tready),
        .m_tdata(td[1]), .m_tvalid(tv[1]), .m_tlast(tl[1])
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    logic [31:0] e_data [2];
    logic [31:0] e_seq  [2];
    logic        e_valid[2];
    logic        e_first[2];
    int          e_left [2];
    string       e_tag  [2];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic rdy, input logic rst);
        logic [1:0][31:0] h_td;
        logic [1:0]       h_tv;
        logic [1:0]       h_tl;
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            check(e_tag[i], 32'(tv[i]), 32'(e_valid[i]));
            check("R6", 32'(tl[i]), 32'(e_valid[i]));
            check(e_valid[i] ? (i == 1 ? "R8" : "R7") : e_tag[i], td[i], e_data[i]);
            if (tv[i]) check("R2", 32'(td[i][1:0]), 32'd0);
        end
        h_td = td; h_tv = tv; h_tl = tl;
        tready = rdy;
        rst_n  = rst;
        #1;
        for (int i = 0; i < 2; i++) begin
            check("R9", td[i], h_td[i]);
            check("R9", 32'(tv[i]), 32'(h_tv[i]));
            check("R9", 32'(tl[i]), 32'(h_tl[i]));
        end
        for (int i = 0; i < 2; i++) begin
            if (!rst) begin
                e_valid[i] = 1'b0;
                e_data[i]  = INITS[i];
                e_seq[i]   = INITS[i];
                e_first[i] = 1'b1;
                e_left[i]  = 0;
                e_tag[i]   = "R1";
            end else if (e_first[i]) begin
                e_first[i] = 1'b0;
                e_valid[i] = 1'b1;
                e_tag[i]   = "R1";
            end else if (e_valid[i] && rdy) begin
                if (h_tv[i]) check(i == 1 ? "R8" : "R7", h_td[i], e_seq[i]);
                e_seq[i]   = e_seq[i] + 32'd12;
                e_valid[i] = 1'b0;
                e_data[i]  = e_data[i] + 32'd3;
                e_left[i]  = 3;
                e_tag[i]   = "R4";
            end else if (e_valid[i]) begin
                e_tag[i] = "R3";
            end else begin
                e_data[i] = e_data[i] + 32'd3;
                e_left[i] = e_left[i] - 1;
                if (e_left[i] == 0) e_valid[i] = 1'b1;
                e_tag[i] = "R5";
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            e_valid[i] = 1'b0;
            e_data[i]  = INITS[i];
            e_seq[i]   = INITS[i];
            e_first[i] = 1'b1;
            e_left[i]  = 0;
            e_tag[i]   = "R1";
        end
        @(posedge clk);
        repeat (4) step(1'b0, 1'b0);          // R1: held in reset
        repeat (40) step(1'b1, 1'b1);         // R7: full-rate acceptance
        repeat (25) step(1'b0, 1'b1);         // R3: long stall
        for (int k = 0; k < 60; k++) step(k % 7 == 0, 1'b1);
        for (int k = 0; k < 2000; k++) step(1'($urandom_range(0, 1)), 1'b1);
        repeat (3) step(1'b1, 1'b0);          // R1: reset mid-stream
        for (int k = 0; k < 600; k++) step($urandom_range(0, 3) == 0, 1'b1);
        step(1'b0, 1'b1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1..: run did not finish, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule